// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounting Unit

This block keeps cycle accounts for an in-order pipeline without stalling anything itself. Each cycle it may receive one instruction event: the execution unit class, up to two source register numbers (each with its own valid flag), the destination register of a load, and whether a control transfer was taken. It charges load-use stall cycles when an instruction reads a register that an earlier load is still writing. It charges a fixed penalty for taken control transfers and counts taken and untaken transfers separately.

Load destinations are recorded in a pending register mask. They become visible to hazard checks only when an instruction-boundary strobe copies the pending mask into the active mask. Each checked source operand is judged and charged on its own, so one instruction can be charged twice. All four counters saturate and can be cleared synchronously.

Top module: `stall_acct`

## Requirements
- R1: After reset all four counters read zero and both register masks are empty, so no source read causes a stall.
- R2: A load event (unit code 4) sets the bit for `ld_dst` in the pending mask. That bit does not affect hazard checks before the next boundary strobe.
- R3: When `insn_end` is high, the active mask is replaced by the pending mask, which includes a load in the same cycle. The pending mask is then emptied. `insn_end` works whether `evt_valid` is high or low.
- R4: Exec (code 0), compare (code 1) and MAC (code 2) events check both sources. Each source that is valid and marked in the active mask adds 2 to the load-stall counter, so one event can add up to 4.
- R5: A control-transfer event (code 3) checks source slot 0 only. Store (code 5) and load events check no source.
- R6: A source whose valid flag is low never causes a stall, whatever its register number.
- R7: A control-transfer event with `br_taken` high adds 2 to the branch-stall counter and 1 to the taken counter. With `br_taken` low it adds 1 to the untaken counter only.
- R8: Every counter saturates at its all-ones value instead of wrapping.
- R9: `clr` zeroes all four counters in the next cycle and takes priority over an event in the same cycle.
- R10: With `evt_valid` low, or with an unused unit code (6 or 7), the counters do not change.
- R11: Counter updates appear on the outputs one clock edge after the event is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of all counters |
| evt_valid | input | 1 | An instruction event is present this cycle |
| evt_unit | input | 3 | Unit class: 0 exec, 1 compare, 2 MAC, 3 control transfer, 4 load, 5 store |
| src_idx | input | NUM_SRC*IDX_W (8) | Source register numbers, slot 0 in the low bits |
| src_vld | input | NUM_SRC (2) | Valid flag per source slot |
| ld_dst | input | IDX_W (4) | Destination register of a load event |
| br_taken | input | 1 | Control transfer was taken |
| insn_end | input | 1 | Instruction-boundary strobe |
| load_stall_cnt | output | CNT_W (32) | Accumulated load-use stall cycles |
| branch_stall_cnt | output | CNT_W (32) | Accumulated taken-transfer stall cycles |
| taken_cnt | output | CNT_W (32) | Number of taken control transfers |
| untaken_cnt | output | CNT_W (32) | Number of untaken control transfers |

## Verification
On every cycle the assertions check several counter properties. Counters never decrease except through a clear, and the load-stall counter never rises by more than two penalties per event. Taken and untaken counts never move together. A clear empties all counters, and idle cycles and store events leave the counters unchanged. Only the bench scenarios can show the mask behaviour: a load staying hidden until the boundary, a boundary replacing older active bits, per-slot checking by unit class, and saturation at the exact limit.

// File: rtl/stall_acct_pkg.sv
`timescale 1ns/1ps
package stall_acct_pkg;

    typedef enum logic [2:0] {
        UNIT_EXEC  = 3'd0,
        UNIT_CMP   = 3'd1,
        UNIT_MAC   = 3'd2,
        UNIT_CTI   = 3'd3,
        UNIT_LOAD  = 3'd4,
        UNIT_STORE = 3'd5
    } unit_e;

    // Whether a unit class inspects a given source slot.
    function automatic logic slot_checked(input logic [2:0] unit, input int slot);
        if (slot == 0)
            return (unit == UNIT_EXEC) || (unit == UNIT_CMP) ||
                   (unit == UNIT_MAC)  || (unit == UNIT_CTI);
        else
            return (unit == UNIT_EXEC) || (unit == UNIT_CMP) ||
                   (unit == UNIT_MAC);
    endfunction

endpackage

// File: rtl/stall_src_check.sv
`timescale 1ns/1ps
module stall_src_check #(
    parameter int REG_N = 16,
    localparam int IDX_W = $clog2(REG_N)
) (
    input  logic             en,
    input  logic             vld,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_N-1:0] mask,
    output logic             hit
);
    always_comb begin
        hit = en && vld && mask[idx];
    end
endmodule

// File: rtl/stall_sat_add.sv
`timescale 1ns/1ps
module stall_sat_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] inc,
    output logic [W-1:0] sum
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, base} + {1'b0, inc};
        sum  = wide[W] ? {W{1'b1}} : wide[W-1:0];
    end
endmodule

// File: rtl/stall_acct.sv
`timescale 1ns/1ps
module stall_acct
    import stall_acct_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int REG_N    = 16,
    parameter int NUM_SRC  = 2,
    parameter int LOAD_PEN = 2,
    parameter int BR_PEN   = 2,
    localparam int IDX_W   = $clog2(REG_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     evt_valid,
    input  logic [2:0]               evt_unit,
    input  logic [NUM_SRC*IDX_W-1:0] src_idx,
    input  logic [NUM_SRC-1:0]       src_vld,
    input  logic [IDX_W-1:0]         ld_dst,
    input  logic                     br_taken,
    input  logic                     insn_end,
    output logic [CNT_W-1:0]         load_stall_cnt,
    output logic [CNT_W-1:0]         branch_stall_cnt,
    output logic [CNT_W-1:0]         taken_cnt,
    output logic [CNT_W-1:0]         untaken_cnt
);

    localparam int HIT_W = $clog2(NUM_SRC + 1);

    typedef struct packed {
        logic [REG_N-1:0] pend;
        logic [REG_N-1:0] act;
        logic [CNT_W-1:0] ls;
        logic [CNT_W-1:0] bs;
        logic [CNT_W-1:0] tk;
        logic [CNT_W-1:0] ut;
    } acct_t;

    acct_t st_q, st_d;

    logic [NUM_SRC-1:0] src_hit;
    logic [HIT_W-1:0]   hit_num;
    logic               is_cti, is_load;
    logic [CNT_W-1:0]   ls_inc, bs_inc, tk_inc, ut_inc;
    logic [CNT_W-1:0]   ls_sum, bs_sum, tk_sum, ut_sum;
    logic [REG_N-1:0]   ld_bit;

    // One hazard checker per source slot.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        stall_src_check #(.REG_N(REG_N)) u_chk (
            .en   (evt_valid && slot_checked(evt_unit, g)),
            .vld  (src_vld[g]),
            .idx  (src_idx[g*IDX_W +: IDX_W]),
            .mask (st_q.act),
            .hit  (src_hit[g])
        );
    end

    always_comb begin
        hit_num = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            hit_num = hit_num + HIT_W'(src_hit[i]);
        end
    end

    always_comb begin
        is_cti  = evt_valid && (evt_unit == UNIT_CTI);
        is_load = evt_valid && (evt_unit == UNIT_LOAD);
        ls_inc  = CNT_W'(hit_num) * CNT_W'(LOAD_PEN);
        bs_inc  = (is_cti && br_taken)  ? CNT_W'(BR_PEN) : '0;
        tk_inc  = (is_cti && br_taken)  ? CNT_W'(1)      : '0;
        ut_inc  = (is_cti && !br_taken) ? CNT_W'(1)      : '0;
        ld_bit  = is_load ? (REG_N'(1) << ld_dst) : '0;
    end

    stall_sat_add #(.W(CNT_W)) u_ls_add (.base(st_q.ls), .inc(ls_inc), .sum(ls_sum));
    stall_sat_add #(.W(CNT_W)) u_bs_add (.base(st_q.bs), .inc(bs_inc), .sum(bs_sum));
    stall_sat_add #(.W(CNT_W)) u_tk_add (.base(st_q.tk), .inc(tk_inc), .sum(tk_sum));
    stall_sat_add #(.W(CNT_W)) u_ut_add (.base(st_q.ut), .inc(ut_inc), .sum(ut_sum));

    always_comb begin
        st_d = st_q;
        // Mask bookkeeping: a load joins the pending set; a boundary
        // publishes that set and starts a fresh one.
        st_d.pend = st_q.pend | ld_bit;
        if (insn_end) begin
            st_d.act  = st_q.pend | ld_bit;
            st_d.pend = '0;
        end
        if (clr) begin
            st_d.ls = '0;
            st_d.bs = '0;
            st_d.tk = '0;
            st_d.ut = '0;
        end else begin
            st_d.ls = ls_sum;
            st_d.bs = bs_sum;
            st_d.tk = tk_sum;
            st_d.ut = ut_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        load_stall_cnt   = st_q.ls;
        branch_stall_cnt = st_q.bs;
        taken_cnt        = st_q.tk;
        untaken_cnt      = st_q.ut;
    end

endmodule

// File: rtl/stall_acct_chk.sv
`timescale 1ns/1ps
module stall_acct_chk
    import stall_acct_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_SRC  = 2,
    parameter int LOAD_PEN = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             evt_valid,
    input logic [2:0]       evt_unit,
    input logic             br_taken,
    input logic [CNT_W-1:0] load_stall_cnt,
    input logic [CNT_W-1:0] branch_stall_cnt,
    input logic [CNT_W-1:0] taken_cnt,
    input logic [CNT_W-1:0] untaken_cnt
);
    localparam logic [CNT_W-1:0] TOP     = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MAX_INC = CNT_W'(NUM_SRC * LOAD_PEN);

    // R8
    ls_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> load_stall_cnt >= $past(load_stall_cnt));

    // R4
    ls_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (load_stall_cnt - $past(load_stall_cnt)) <= MAX_INC);

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (load_stall_cnt == '0) && (branch_stall_cnt == '0) &&
                (taken_cnt == '0) && (untaken_cnt == '0));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid && !clr) |=> $stable(load_stall_cnt) && $stable(branch_stall_cnt) &&
                                 $stable(taken_cnt) && $stable(untaken_cnt));

    // R5
    store_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_unit == UNIT_STORE && !clr) |=>
            $stable(load_stall_cnt) && $stable(taken_cnt) && $stable(untaken_cnt));

    // R7
    taken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_unit == UNIT_CTI && br_taken && !clr && taken_cnt != TOP) |=>
            (taken_cnt == $past(taken_cnt) + CNT_W'(1)) && $stable(untaken_cnt));

    // R7
    untaken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_unit == UNIT_CTI && !br_taken && !clr && untaken_cnt != TOP) |=>
            (untaken_cnt == $past(untaken_cnt) + CNT_W'(1)) && $stable(taken_cnt) &&
            $stable(branch_stall_cnt));
endmodule

bind stall_acct stall_acct_chk #(
    .CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .LOAD_PEN(LOAD_PEN)
) u_stall_acct_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt_valid(evt_valid),
    .evt_unit(evt_unit), .br_taken(br_taken),
    .load_stall_cnt(load_stall_cnt), .branch_stall_cnt(branch_stall_cnt),
    .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
);

// File: tb/stall_acct_bench.sv
`timescale 1ns/1ps
module stall_acct_bench;
    localparam int W   = 6;
    localparam int TOP = (1 << W) - 1;

    typedef struct {
        int    ls, bs, tk, ut;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0, evt_valid = 1'b0, br_taken = 1'b0, insn_end = 1'b0;
    logic [2:0]   evt_unit = '0;
    logic [7:0]   src_idx = '0;
    logic [1:0]   src_vld = '0;
    logic [3:0]   ld_dst = '0;
    logic [W-1:0] load_stall_cnt, branch_stall_cnt, taken_cnt, untaken_cnt;

    int checks = 0, fails = 0;
    bit done = 0;
    exp_t sb[$];

    int m_ls = 0, m_bs = 0, m_tk = 0, m_ut = 0;
    logic [15:0] m_pend = '0, m_act = '0;

    stall_acct #(.CNT_W(W)) u_stall_acct (
        .clk(clk), .rst_n(rst_n), .clr(clr), .evt_valid(evt_valid),
        .evt_unit(evt_unit), .src_idx(src_idx), .src_vld(src_vld),
        .ld_dst(ld_dst), .br_taken(br_taken), .insn_end(insn_end),
        .load_stall_cnt(load_stall_cnt), .branch_stall_cnt(branch_stall_cnt),
        .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
    );

    always #2 clk = ~clk;

    function automatic int sat(input int x, input int inc);
        return (x + inc > TOP) ? TOP : x + inc;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    // Driver: present one cycle of stimulus at a falling edge, update model, queue result.
    task automatic step(input logic v, input logic [2:0] u,
                        input logic [3:0] a, input logic va,
                        input logic [3:0] b, input logic vb,
                        input logic [3:0] d, input logic tk,
                        input logic bnd, input logic cl, input string tag);
        exp_t e;
        int hits;
        logic [15:0] ldb;
        evt_valid = v; evt_unit = u; src_idx = {b, a}; src_vld = {vb, va};
        ld_dst = d; br_taken = tk; insn_end = bnd; clr = cl;
        hits = 0;
        if (v && u <= 3'd3 && va && m_act[a]) hits++;
        if (v && u <= 3'd2 && vb && m_act[b]) hits++;
        ldb = (v && u == 3'd4) ? (16'd1 << d) : 16'd0;
        m_pend = m_pend | ldb;
        if (bnd) begin m_act = m_pend; m_pend = '0; end
        if (cl) begin
            m_ls = 0; m_bs = 0; m_tk = 0; m_ut = 0;
        end else begin
            m_ls = sat(m_ls, 2 * hits);
            if (v && u == 3'd3) begin
                if (tk) begin m_bs = sat(m_bs, 2); m_tk = sat(m_tk, 1); end
                else    m_ut = sat(m_ut, 1);
            end
        end
        e.ls = m_ls; e.bs = m_bs; e.tk = m_tk; e.ut = m_ut; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: R11 - result of a falling-edge stimulus is visible just after the next rise.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.tag, int'(load_stall_cnt),   e.ls, "load_stall");
            cmp(e.tag, int'(branch_stall_cnt), e.bs, "branch_stall");
            cmp(e.tag, int'(taken_cnt),        e.tk, "taken");
            cmp(e.tag, int'(untaken_cnt),      e.ut, "untaken");
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", int'(load_stall_cnt) + int'(branch_stall_cnt) +
                  int'(taken_cnt) + int'(untaken_cnt), 0, "counters_in_reset");
        rst_n = 1'b1;
        @(negedge clk);
        step(1, 3'd0, 4'd3, 1, 4'd9, 1, 0, 0, 1, 0, "R1_empty_masks");
        // R2: load hidden until boundary
        step(1, 3'd4, 0, 0, 0, 0, 4'd3, 0, 0, 0, "R2_load");
        step(1, 3'd0, 4'd3, 1, 4'd3, 1, 0, 0, 0, 0, "R2_hidden");
        // R3: boundary without event publishes
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 1, 0, "R3_publish");
        // R4: per-source charging
        step(1, 3'd0, 4'd3, 1, 4'd5, 1, 0, 0, 0, 0, "R4_exec_one");
        step(1, 3'd1, 4'd3, 1, 4'd3, 1, 0, 0, 0, 0, "R4_cmp_both");
        step(1, 3'd2, 4'd5, 1, 4'd3, 1, 0, 0, 0, 0, "R4_mac_slot1");
        // R6: invalid source ignored
        step(1, 3'd0, 4'd3, 0, 4'd3, 0, 0, 0, 0, 0, "R6_invalid");
        // R5 / R7: control transfers
        step(1, 3'd3, 4'd3, 1, 4'd3, 1, 0, 1, 0, 0, "R5_R7_cti_taken");
        step(1, 3'd3, 4'd1, 1, 4'd3, 1, 0, 0, 0, 0, "R5_R7_cti_untaken");
        step(1, 3'd5, 4'd3, 1, 4'd3, 1, 0, 0, 0, 0, "R5_store");
        step(1, 3'd4, 4'd3, 1, 4'd3, 1, 4'd7, 0, 1, 0, "R5_R3_load_with_boundary");
        // R3: active mask replaced
        step(1, 3'd0, 4'd3, 1, 4'd3, 1, 0, 0, 0, 0, "R3_old_gone");
        step(1, 3'd0, 4'd7, 1, 4'd0, 0, 0, 0, 0, 0, "R3_new_seen");
        // R10: ignored events
        step(1, 3'd6, 4'd7, 1, 4'd7, 1, 0, 1, 0, 0, "R10_code6");
        step(1, 3'd7, 4'd7, 1, 4'd7, 1, 0, 1, 0, 0, "R10_code7");
        step(0, 3'd3, 4'd7, 1, 4'd7, 1, 0, 1, 0, 0, "R10_not_valid");
        // R9: clear wins over a taken transfer
        step(1, 3'd3, 4'd7, 1, 0, 0, 0, 1, 0, 1, "R9_clear_priority");
        idle("R9_after_clear");
        // R8: saturation
        for (int i = 0; i < 17; i++) step(1, 3'd2, 4'd7, 1, 4'd7, 1, 0, 0, 0, 0, "R8_ls_sat");
        for (int i = 0; i < 34; i++) step(1, 3'd3, 4'd0, 0, 0, 0, 0, 1, 0, 0, "R8_bs_sat");
        for (int i = 0; i < 66; i++) step(1, 3'd3, 4'd0, 0, 0, 0, 0, 0, 0, 0, "R8_ut_sat");
        idle("R8_hold");
        idle("R11_drain");
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule